// File: doc/BRIEF.md
# Sensor Output Delay Pipeline with Preblanking

This block is the digital back end of an image sensor front end. Each rising edge of the sample clock captures one converted code, and the block returns that code on its registered output a fixed number of edges later. The conversion itself happens upstream. This block only aligns timing and forces the output to zero.

An active-low blanking request lets the system force the output word to all zeros during intervals when the sensor output is meaningless. The request does not use the data delay. It travels through a separate, longer delay line. The zeroed window therefore begins on a fixed edge after the request drops and ends on a fixed edge after it rises again. Both latencies are parameters. They default to seven edges for data and nine edges for blanking.

Top module: `sample_out_pipe`

## Requirements
- R1: Every bit of the 10-bit code passes through without change when blanking is not in effect. Codes 10'h3FF, 10'h155 and 10'h2AA come out exactly as they went in.
- R2: A code captured on rising edge n appears on `code_out` right after rising edge n+7.
- R3: `blank_req_n` is active low. Let s be the first rising edge that samples it low. From edge s+8 onward, `code_out` is all zeros. Edge s+8 is the ninth edge counted from the moment the request dropped.
- R4: Blanking never takes effect early. The output produced at edge s+7 is still the normal delayed code.
- R5: Let s' be the first edge that samples `blank_req_n` high again. The output after edge s'+8 is the code captured at edge s'+1. No sample is lost or held back, and the normal latency of R2 applies from that point on.
- R6: If `blank_req_n` is sampled low on exactly one edge, exactly one output cycle is zeroed. The outputs on either side of that cycle carry their normal codes.
- R7: While `rst` is sampled high, `code_out` is zero after each edge. Reset also clears every stage. The first seven outputs after reset is released are therefore zero, and none of them carries a code from before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | 10 | Converted sample code, one per clock |
| blank_req_n | input | 1 | Preblanking request, active low |
| code_out | output | 10 | Registered, delayed output code |

## Verification
The main stimulus is an incrementing code that wraps from 1023 to 0. Each expected value is then unique within any window, so the pattern shows whether the latency is exactly seven edges and not six or eight. Bit patterns 3FF, 155 and 2AA expose stuck or swapped bits that a slow count would take long to reach. Blanking is tried with three shapes: a long low interval, single-cycle pulses and a two-cycle pulse. With these, the entry and exit edges of the zeroed window can be told apart from an off-by-one delay or a pulse that gets stretched or dropped. A reset in the middle of a run, followed at once by a blanking request, checks that the pipeline is cleared and that blanking still lines up right after reset.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int CODE_W          = 10;
    localparam int DATA_LAT_DEF    = 7;
    localparam int BLANK_EDGES_DEF = 9;

    typedef logic [CODE_W-1:0] code_t;

    // One captured lane: the code and the (active-high) blank flag taken on the same edge.
    typedef struct packed {
        code_t code;
        logic  blank;
    } lane_t;

    function automatic code_t gate_code(input code_t c, input logic kill);
        return kill ? '0 : c;
    endfunction

endpackage

// File: rtl/sop_capture.sv
module sop_capture
    import sop_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t code_in,
    input  logic  blank_req_n,
    output lane_t lane
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lane <= '0;
        end else begin
            lane.code  <= code_in;
            lane.blank <= ~blank_req_n;
        end
    end

endmodule

// File: rtl/sop_delay.sv
module sop_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0][W-1:0] tap;

    always_ff @(posedge clk) begin
        if (rst) begin
            tap <= '0;
        end else begin
            tap[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                tap[i] <= tap[i-1];
            end
        end
    end

    assign dout = tap[LAST];

endmodule

// File: rtl/sop_out_stage.sv
module sop_out_stage
    import sop_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t code_d,
    input  logic  kill_d,
    output code_t code_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_out <= '0;
        end else begin
            code_out <= gate_code(code_d, kill_d);
        end
    end

endmodule

// File: rtl/sample_out_pipe.sv
module sample_out_pipe
    import sop_pkg::*;
#(
    parameter int DATA_LAT    = DATA_LAT_DEF,
    parameter int BLANK_EDGES = BLANK_EDGES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    input  logic              blank_req_n,
    output logic [CODE_W-1:0] code_out
);

    // Capture and output register each take one edge; the rest is delay line.
    localparam int DATA_DLY  = DATA_LAT - 1;
    localparam int BLANK_DLY = BLANK_EDGES - 2;

    lane_t cap;
    code_t code_dly;
    logic  kill_dly;

    sop_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .code_in     (code_in),
        .blank_req_n (blank_req_n),
        .lane        (cap)
    );

    sop_delay #(.W(CODE_W), .DEPTH(DATA_DLY)) u_data_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (cap.code),
        .dout (code_dly)
    );

    sop_delay #(.W(1), .DEPTH(BLANK_DLY)) u_blank_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (cap.blank),
        .dout (kill_dly)
    );

    sop_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .code_d   (code_dly),
        .kill_d   (kill_dly),
        .code_out (code_out)
    );

endmodule

// File: rtl/sop_checker.sv
module sop_checker
    import sop_pkg::*;
#(
    parameter int DATA_LAT    = DATA_LAT_DEF,
    parameter int BLANK_EDGES = BLANK_EDGES_DEF
) (
    input logic  clk,
    input logic  rst,
    input code_t code_in,
    input logic  blank_req_n,
    input code_t code_out
);

    // Input history as seen at the ports; index k holds the value from k+1 edges back at sampling time.
    logic [DATA_LAT:0][CODE_W-1:0] cin_h;
    logic [BLANK_EDGES-1:0]        blk_h;

    always_ff @(posedge clk) begin
        if (rst) begin
            cin_h <= '0;
            blk_h <= '0;
        end else begin
            cin_h <= {cin_h[DATA_LAT-1:0], code_in};
            blk_h <= {blk_h[BLANK_EDGES-2:0], ~blank_req_n};
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> code_out == '0); // R7

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !blk_h[BLANK_EDGES-1] |-> code_out == cin_h[DATA_LAT]); // R2

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        blk_h[BLANK_EDGES-1] |-> code_out == '0); // R3

    AST_RESUME_FRESH: assert property (@(posedge clk) disable iff (rst)
        $fell(blk_h[BLANK_EDGES-1]) |-> code_out == cin_h[DATA_LAT]); // R5

    AST_PULSE_ONE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (blk_h[BLANK_EDGES-1] && !blk_h[BLANK_EDGES-2]) |=> code_out == cin_h[DATA_LAT]); // R6

endmodule

bind sample_out_pipe sop_checker #(
    .DATA_LAT    (DATA_LAT),
    .BLANK_EDGES (BLANK_EDGES)
) u_sop_chk (.*);

// File: tb/tb_sample_out_pipe.sv
module tb_sample_out_pipe;
    import sop_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    code_t code_in = '0;
    logic  blank_req_n = 1'b1;
    code_t code_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    code_t exp_q[$];
    string tag_q[$];
    logic  prev1 = 1'b0;
    logic  prev2 = 1'b0;

    always #2 clk = ~clk;

    sample_out_pipe dut (
        .clk         (clk),
        .rst         (rst),
        .code_in     (code_in),
        .blank_req_n (blank_req_n),
        .code_out    (code_out)
    );

    // Sets inputs for the coming edge and queues the value expected 7 edges after it.
    task automatic drive_now(input code_t c, input logic bn);
        logic  cur;
        code_t e;
        string t;
        cur = ~bn;
        e   = prev1 ? '0 : c;
        if (prev1 && !prev2 && !cur) t = "R6";
        else if (prev1)              t = "R3";
        else if (prev2)              t = "R5";
        else if (cur)                t = "R4";
        else if (c == 10'h3FF || c == 10'h155 || c == 10'h2AA) t = "R1";
        else                         t = "R2";
        code_in     = c;
        blank_req_n = bn;
        exp_q.push_back(e);
        tag_q.push_back(t);
        prev2 = prev1;
        prev1 = cur;
    endtask

    task automatic drive(input code_t c, input logic bn);
        @(negedge clk);
        drive_now(c, bn);
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        exp_q.delete();
        tag_q.delete();
        repeat (cycles) @(negedge clk);
        rst   = 1'b0;
        prev1 = 1'b0;
        prev2 = 1'b0;
        for (int i = 0; i < DATA_LAT_DEF; i++) begin
            exp_q.push_back('0);
            tag_q.push_back("R7");
        end
        drive_now('0, 1'b1);
    endtask

    // Monitor: compares one output per edge, 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (rst) begin
            checks++;
            if (code_out !== '0) begin
                errors++;
                $display("FAIL R7: code_out=%h expected %h during reset", code_out, 10'h000);
            end
        end else if (exp_q.size() > 0) begin
            code_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (code_out !== e) begin
                errors++;
                $display("FAIL %s: code_out=%h expected %h at %0t", t, code_out, e, $time);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        code_t cnt;
        // R7: power-up reset
        do_reset(5);
        cnt = 10'd1;
        // R2: incrementing codes
        for (int i = 0; i < 30; i++) begin drive(cnt, 1'b1); cnt++; end
        // R3/R4/R5: long blanking interval
        for (int i = 0; i < 12; i++) begin drive(cnt, 1'b0); cnt++; end
        for (int i = 0; i < 20; i++) begin drive(cnt, 1'b1); cnt++; end
        // R6: single-cycle pulses
        drive(cnt, 1'b0); cnt++;
        for (int i = 0; i < 15; i++) begin drive(cnt, 1'b1); cnt++; end
        drive(cnt, 1'b0); cnt++;
        for (int i = 0; i < 12; i++) begin drive(cnt, 1'b1); cnt++; end
        // two-cycle pulse: exactly two zeroed outputs
        for (int i = 0; i < 2; i++) begin drive(cnt, 1'b0); cnt++; end
        for (int i = 0; i < 12; i++) begin drive(cnt, 1'b1); cnt++; end
        // R1: bit patterns
        for (int i = 0; i < 4; i++) begin
            drive(10'h3FF, 1'b1); drive(10'h155, 1'b1);
            drive(10'h2AA, 1'b1); drive(10'h000, 1'b1);
        end
        // R2: wrap from 1023 to 0
        cnt = 10'd1015;
        for (int i = 0; i < 20; i++) begin drive(cnt, 1'b1); cnt++; end
        // R7: mid-run reset, then blanking right after release
        do_reset(3);
        cnt = 10'd500;
        for (int i = 0; i < 3; i++) begin drive(cnt, 1'b0); cnt++; end
        for (int i = 0; i < 20; i++) begin drive(cnt, 1'b1); cnt++; end
        // drain
        for (int i = 0; i < 12; i++) begin drive(cnt, 1'b1); cnt++; end
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule